// File: doc/BRIEF.md
# ATA Task-File Register Interface

This block is the host-facing register file of an ATA-style storage device. A host reaches it over a simple register bus with one address, a read strobe and a write strobe. The bus carries the parameter bytes (feature, sector count, three address bytes, drive/head), the command and status pair, and the control byte. The 16-bit data port is not stored here. Accesses to it are turned into strobes toward an external PIO FIFO.

Parameter and command writes are taken only while the device is idle. Idle means the busy flag and the data-request flag of the status register are both clear. An accepted command write produces a one-cycle command strobe carrying the command byte, and it marks the device busy. The interrupt-pending flag is set by the device. It is dropped by a status read or an accepted command write, but not by an alternate-status read. The interrupt output is the pending flag, masked by the interrupt-disable bit of the control byte. The device side loads the status and error registers through its own write strobes.

Top module: `ata_taskfile_regs`

## Requirements
- R1: After reset:
  - all five parameter registers, the feature register, the error register and the control byte read as 0;
  - status reads as the parameter STATUS_RST (default 8'h50);
  - `irq` and `cmd_valid` are 0.
- R2: The parameter registers live at these addresses: count at 2, address byte 0 at 3, address byte 1 at 4, address byte 2 at 5, drive/head at 6.
  - When status bit 7 (busy) and bit 3 (data request) are both 0, a write stores `bus_wdata[7:0]` in the addressed register.
  - A read at the same address then returns that byte, and the other parameter registers are unchanged.
- R3: While status bit 7 or bit 3 is 1, writes to addresses 1 through 7 are ignored. The stored bytes keep their values and no command strobe occurs.
- R4: An accepted write at address 1 stores the feature byte, which is visible on `feature`. A read at address 1 returns the error register, not the feature byte.
- R5: An accepted write at address 7 has these effects:
  - in the next cycle, `cmd_valid` is 1 for exactly one cycle with `cmd_code` equal to the written byte;
  - status bit 7 becomes 1;
  - the pending interrupt is cleared.
- R6: A read at address 7 returns the status register in the same cycle. From the next cycle on, the pending interrupt is cleared.
- R7: A read at address 8 returns the same status value and leaves the pending interrupt unchanged.
- R8: A write at address 8 always loads the control byte `dev_ctrl`, whatever the busy state. `irq` equals the pending flag while `dev_ctrl[1]` is 0, and is 0 while `dev_ctrl[1]` is 1.
- R9: `dev_irq_set` sets the pending flag in the next cycle. When it coincides with a clearing read or command write, the set wins.
- R10: `dev_status_we` loads `dev_status_in` into the status register, and `dev_error_we` loads `dev_error_in` into the error register, each one cycle later.
- R11: Address 0 is the data port:
  - a write drives `pio_wr_strobe` with `pio_wr_data` equal to `bus_wdata` in the same cycle;
  - a read drives `pio_rd_strobe` and returns `pio_rd_data` on `bus_rdata` in the same cycle;
  - neither strobe is asserted for any other address.
- R12: Addresses 9 to 15 read as 0, and writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (drives read side effects) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the current address |
| pio_wr_strobe | output | 1 | Data-port write toward the FIFO |
| pio_wr_data | output | DATA_W | Data-port write word |
| pio_rd_strobe | output | 1 | Data-port read toward the FIFO |
| pio_rd_data | input | DATA_W | Data-port word from the FIFO |
| dev_status_we | input | 1 | Device loads the status register |
| dev_status_in | input | 8 | New status value |
| dev_error_we | input | 1 | Device loads the error register |
| dev_error_in | input | 8 | New error value |
| dev_irq_set | input | 1 | Device raises its interrupt |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_code | output | 8 | Command byte |
| feature | output | 8 | Stored feature byte |
| dev_ctrl | output | 8 | Control byte |
| irq | output | 1 | Masked interrupt request |

## Verification
Write acceptance is swept over all 256 status values. This separates a gate that decodes exactly bits 7 and 3 from one that looks at a neighbouring bit or at only one of the two. Each parameter address is written with a spread of byte values, and all five registers are compared after every write. This exposes a wrong decode, crossed storage or a lost byte. The interrupt flag is driven through set, alternate read, status read, command write, masking and a set that coincides with a clear, so each of the clearing paths is tested in isolation.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

    localparam int REG_W   = 8;
    localparam int N_PARAM = 5;   // count, addr0, addr1, addr2, drive/head

    localparam int BSY_BIT  = 7;
    localparam int DRQ_BIT  = 3;
    localparam int NIEN_BIT = 1;

    localparam int A_DATA  = 0;
    localparam int A_FEAT  = 1;
    localparam int A_PARAM = 2;   // first parameter address
    localparam int A_CMD   = 7;
    localparam int A_CTL   = 8;

    typedef struct packed {
        logic               data;
        logic               feat;
        logic               cmd;
        logic               ctl;
        logic [N_PARAM-1:0] param;
    } tf_sel_t;

endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode
    import ata_tf_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output tf_sel_t           sel
);

    always_comb begin
        sel.data = (addr == ADDR_W'(A_DATA));
        sel.feat = (addr == ADDR_W'(A_FEAT));
        sel.cmd  = (addr == ADDR_W'(A_CMD));
        sel.ctl  = (addr == ADDR_W'(A_CTL));
        for (int i = 0; i < N_PARAM; i++) begin
            sel.param[i] = (addr == ADDR_W'(A_PARAM + i));
        end
    end

endmodule

// File: rtl/ata_tf_status.sv
module ata_tf_status
    import ata_tf_pkg::*;
#(
    parameter logic [REG_W-1:0] STATUS_RST = 8'h50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dev_status_we,
    input  logic [REG_W-1:0] dev_status_in,
    input  logic             dev_irq_set,
    input  logic             cmd_go,
    input  logic             status_rd,
    input  logic             nien,
    output logic [REG_W-1:0] status_q,
    output logic             pending_q,
    output logic             irq
);

    typedef struct packed {
        logic [REG_W-1:0] status;
        logic             pending;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (dev_status_we) st_d.status = dev_status_in;
        if (cmd_go)        st_d.status[BSY_BIT] = 1'b1;
        if (cmd_go || status_rd) st_d.pending = 1'b0;
        if (dev_irq_set)   st_d.pending = 1'b1;   // device set wins
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.status  <= STATUS_RST;
            st_q.pending <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_q  = st_q.status;
    assign pending_q = st_q.pending;
    assign irq       = st_q.pending & ~nien;

endmodule

// File: rtl/ata_tf_rdmux.sv
module ata_tf_rdmux
    import ata_tf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  tf_sel_t                        sel,
    input  logic [DATA_W-1:0]              pio_rd_data,
    input  logic [REG_W-1:0]               error_q,
    input  logic [N_PARAM-1:0][REG_W-1:0]  param_q,
    input  logic [REG_W-1:0]               status_q,
    output logic [DATA_W-1:0]              rdata
);

    always_comb begin
        rdata = '0;
        if (sel.data) rdata = pio_rd_data;
        if (sel.feat) rdata = DATA_W'(error_q);
        for (int i = 0; i < N_PARAM; i++) begin
            if (sel.param[i]) rdata = DATA_W'(param_q[i]);
        end
        if (sel.cmd || sel.ctl) rdata = DATA_W'(status_q);
    end

endmodule

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs
    import ata_tf_pkg::*;
#(
    parameter int               ADDR_W     = 4,
    parameter int               DATA_W     = 16,
    parameter logic [REG_W-1:0] STATUS_RST = 8'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pio_wr_strobe,
    output logic [DATA_W-1:0] pio_wr_data,
    output logic              pio_rd_strobe,
    input  logic [DATA_W-1:0] pio_rd_data,
    input  logic              dev_status_we,
    input  logic [REG_W-1:0]  dev_status_in,
    input  logic              dev_error_we,
    input  logic [REG_W-1:0]  dev_error_in,
    input  logic              dev_irq_set,
    output logic              cmd_valid,
    output logic [REG_W-1:0]  cmd_code,
    output logic [REG_W-1:0]  feature,
    output logic [REG_W-1:0]  dev_ctrl,
    output logic              irq
);

    typedef struct packed {
        logic [N_PARAM-1:0][REG_W-1:0] param;
        logic [REG_W-1:0]              feature;
        logic [REG_W-1:0]              error;
        logic [REG_W-1:0]              devctl;
        logic                          cmd_valid;
        logic [REG_W-1:0]              cmd_code;
    } tf_t;

    tf_t              tf_d, tf_q;
    tf_sel_t          sel;
    logic [REG_W-1:0] status_q;
    logic             pending_q;
    logic             accept;
    logic             cmd_go;
    logic             status_rd;

    ata_tf_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign accept    = ~status_q[BSY_BIT] & ~status_q[DRQ_BIT];
    assign cmd_go    = bus_wr & sel.cmd & accept;
    assign status_rd = bus_rd & sel.cmd;

    always_comb begin
        tf_d           = tf_q;
        tf_d.cmd_valid = 1'b0;
        if (bus_wr) begin
            if (sel.feat && accept) tf_d.feature = bus_wdata[REG_W-1:0];
            for (int i = 0; i < N_PARAM; i++) begin
                if (sel.param[i] && accept) tf_d.param[i] = bus_wdata[REG_W-1:0];
            end
            if (sel.ctl) tf_d.devctl = bus_wdata[REG_W-1:0];
        end
        if (cmd_go) begin
            tf_d.cmd_valid = 1'b1;
            tf_d.cmd_code  = bus_wdata[REG_W-1:0];
        end
        if (dev_error_we) tf_d.error = dev_error_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tf_q <= '0;
        end else begin
            tf_q <= tf_d;
        end
    end

    ata_tf_status #(.STATUS_RST(STATUS_RST)) u_stat (
        .clk           (clk),
        .rst_n         (rst_n),
        .dev_status_we (dev_status_we),
        .dev_status_in (dev_status_in),
        .dev_irq_set   (dev_irq_set),
        .cmd_go        (cmd_go),
        .status_rd     (status_rd),
        .nien          (tf_q.devctl[NIEN_BIT]),
        .status_q      (status_q),
        .pending_q     (pending_q),
        .irq           (irq)
    );

    ata_tf_rdmux #(.DATA_W(DATA_W)) u_rd (
        .sel         (sel),
        .pio_rd_data (pio_rd_data),
        .error_q     (tf_q.error),
        .param_q     (tf_q.param),
        .status_q    (status_q),
        .rdata       (bus_rdata)
    );

    assign pio_wr_strobe = bus_wr & sel.data;
    assign pio_rd_strobe = bus_rd & sel.data;
    assign pio_wr_data   = bus_wdata;
    assign cmd_valid     = tf_q.cmd_valid;
    assign cmd_code      = tf_q.cmd_code;
    assign feature       = tf_q.feature;
    assign dev_ctrl      = tf_q.devctl;

endmodule

// File: rtl/ata_tf_checker.sv
module ata_tf_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              dev_irq_set,
    input logic              cmd_valid,
    input logic              irq,
    input logic [7:0]        dev_ctrl,
    input logic [7:0]        status_q,
    input logic              pending_q
);

    a_r5_cmd_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    a_r5_cmd_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> status_q[7] || $past(bus_wr));

    a_r3_busy_blocks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(7) && (status_q[7] || status_q[3])) |=> !cmd_valid);

    a_r6_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(7) && !dev_irq_set) |=> !pending_q);

    a_r7_alt_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == ADDR_W'(8) && pending_q) |=> pending_q);

    a_r8_mask_blocks_irq: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ctrl[1] |-> !irq);

    a_r9_set_pending: assert property (@(posedge clk) disable iff (!rst_n)
        dev_irq_set |=> pending_q);

endmodule

bind ata_taskfile_regs ata_tf_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .dev_irq_set (dev_irq_set),
    .cmd_valid   (cmd_valid),
    .irq         (irq),
    .dev_ctrl    (dev_ctrl),
    .status_q    (status_q),
    .pending_q   (pending_q)
);

// File: tb/ata_taskfile_regs_test.sv
`timescale 1ns/1ps
module ata_taskfile_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        pio_wr_strobe, pio_rd_strobe;
    logic [15:0] pio_wr_data;
    logic [15:0] pio_rd_data = '0;
    logic        dev_status_we = 1'b0, dev_error_we = 1'b0, dev_irq_set = 1'b0;
    logic [7:0]  dev_status_in = '0, dev_error_in = '0;
    logic        cmd_valid, irq;
    logic [7:0]  cmd_code, feature, dev_ctrl;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_p [5];
    logic [7:0] cur_status;

    always #2.5 clk = ~clk;

    ata_taskfile_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pio_wr_strobe(pio_wr_strobe), .pio_wr_data(pio_wr_data),
        .pio_rd_strobe(pio_rd_strobe), .pio_rd_data(pio_rd_data),
        .dev_status_we(dev_status_we), .dev_status_in(dev_status_in),
        .dev_error_we(dev_error_we), .dev_error_in(dev_error_in),
        .dev_irq_set(dev_irq_set), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .feature(feature), .dev_ctrl(dev_ctrl), .irq(irq)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // All tasks start and end 1 ns after a rising edge.
    task automatic wr(input logic [3:0] a, input logic [15:0] v);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        #1 check(bus_rdata, exp, tag);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, input logic [15:0] exp, input string tag);
        bus_addr = a;
        #1 check(bus_rdata, exp, tag);
    endtask

    task automatic set_status(input logic [7:0] v);
        dev_status_we = 1'b1; dev_status_in = v;
        @(posedge clk); #1;
        dev_status_we = 1'b0;
        cur_status = v;
    endtask

    task automatic pulse_irq();
        dev_irq_set = 1'b1;
        @(posedge clk); #1;
        dev_irq_set = 1'b0;
    endtask

    task automatic check_params(input string tag);
        for (int i = 0; i < 5; i++) peek(4'(2 + i), {8'h00, exp_p[i]}, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 5; i++) exp_p[i] = 8'h00;
        cur_status = 8'h50;
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;

        // R1 reset state
        check_params("R1 params");
        peek(4'd8, 16'h0050, "R1 status");
        peek(4'd1, 16'h0000, "R1 error");
        check(feature, 0, "R1 feature");
        check(dev_ctrl, 0, "R1 devctl");
        check(irq, 0, "R1 irq");
        check(cmd_valid, 0, "R1 cmd_valid");

        // R2 parameter write/readback sweep
        for (int i = 0; i < 5; i++) begin
            for (int v = 0; v < 256; v += 17) begin
                logic [7:0] b;
                b = 8'(v) ^ 8'(i * 8'h3B);
                wr(4'(2 + i), {8'hC3, b});
                exp_p[i] = b;
                check_params("R2 readback");
            end
        end

        // R3 write gating swept over every status value
        for (int s = 0; s < 256; s++) begin
            logic [7:0] b;
            set_status(8'(s));
            b = 8'(s) ^ 8'hA5;
            wr(4'd4, {8'h00, b});
            if (s[7] == 1'b0 && s[3] == 1'b0) exp_p[2] = b;
            peek(4'd4, {8'h00, exp_p[2]}, "R3 gate sweep");
        end
        set_status(8'h88);
        wr(4'd1, 16'h0077);
        check(feature, 0, "R3 feature blocked");
        wr(4'd7, 16'h00EC);
        check(cmd_valid, 0, "R3 cmd blocked");
        check_params("R3 params unchanged");

        // R10 status and error loads
        set_status(8'h58);
        peek(4'd8, 16'h0058, "R10 status load");
        dev_error_we = 1'b1; dev_error_in = 8'h04;
        @(posedge clk); #1; dev_error_we = 1'b0;
        peek(4'd1, 16'h0004, "R10 error load");

        // R4 feature write vs error read
        set_status(8'h50);
        wr(4'd1, 16'h003C);
        check(feature, 16'h3C, "R4 feature stored");
        peek(4'd1, 16'h0004, "R4 address 1 reads error");

        // R9, R7, R6 pending flag paths
        pulse_irq();
        check(irq, 1, "R9 set");
        rd(4'd8, 16'h0050, "R7 alt read value");
        check(irq, 1, "R7 alt read keeps irq");
        rd(4'd7, 16'h0050, "R6 status read value");
        check(irq, 0, "R6 status read clears irq");
        pulse_irq();
        bus_addr = 4'd7; bus_rd = 1'b1; dev_irq_set = 1'b1;
        @(posedge clk); #1; bus_rd = 1'b0; dev_irq_set = 1'b0;
        check(irq, 1, "R9 set wins over clear");

        // R8 masking
        wr(4'd8, 16'h0002);
        check(dev_ctrl, 16'h02, "R8 devctl load");
        check(irq, 0, "R8 masked");
        wr(4'd8, 16'h0000);
        check(irq, 1, "R8 unmasked");

        // R5 command write
        bus_addr = 4'd7; bus_wdata = 16'h00EC; bus_wr = 1'b1;
        #1 check(cmd_valid, 0, "R5 no strobe before edge");
        @(posedge clk); #1; bus_wr = 1'b0;
        check(cmd_valid, 1, "R5 strobe");
        check(cmd_code, 16'hEC, "R5 code");
        check(irq, 0, "R5 clears irq");
        peek(4'd8, 16'h00D0, "R5 busy set");
        @(posedge clk); #1;
        check(cmd_valid, 0, "R5 strobe one cycle");
        wr(4'd7, 16'h00A1);
        check(cmd_valid, 0, "R3 busy blocks cmd");
        wr(4'd2, 16'h0099);
        check_params("R3 busy blocks param");
        wr(4'd8, 16'h0004);
        check(dev_ctrl, 16'h04, "R8 devctl while busy");
        wr(4'd8, 16'h0000);

        // R11 data port
        bus_addr = 4'd0; bus_wdata = 16'hBEEF; bus_wr = 1'b1;
        #1 check(pio_wr_strobe, 1, "R11 wr strobe");
        check(pio_wr_data, 16'hBEEF, "R11 wr data");
        check(pio_rd_strobe, 0, "R11 no rd strobe on write");
        @(posedge clk); #1; bus_wr = 1'b0;
        pio_rd_data = 16'h1234;
        bus_rd = 1'b1;
        #1 check(pio_rd_strobe, 1, "R11 rd strobe");
        check(bus_rdata, 16'h1234, "R11 rd data");
        bus_addr = 4'd2;
        #1 check(pio_rd_strobe, 0, "R11 no strobe other addr");
        bus_wr = 1'b1;
        #1 check(pio_wr_strobe, 0, "R11 no wr strobe other addr");
        bus_wr = 1'b0; bus_rd = 1'b0;

        // R12 unmapped addresses
        set_status(8'h50);
        for (int a = 9; a < 16; a++) begin
            wr(4'(a), 16'h00FF);
            peek(4'(a), 16'h0000, "R12 unmapped read");
            check(cmd_valid, 0, "R12 no cmd");
        end
        check(dev_ctrl, 0, "R12 devctl untouched");
        check(feature, 16'h3C, "R12 feature untouched");
        check_params("R12 params untouched");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule